// File: doc/BRIEF.md
# Dual-Path Glitch-Free CPU Clock Selector

This block picks the clock that feeds a CPU core. Two identical dynamic paths each choose one of three slow-side sources (the crystal, a fixed half-rate clock and a fixed third-rate clock), optionally pass it through a programmable integer divider, and offer the result to a path-select stage. A final stage chooses between the selected dynamic path and the system PLL output. Both selection stages are glitch-free. The enable of the outgoing clock is withdrawn on that clock's own falling edge. The incoming clock is enabled only after the outgoing enable has been seen low through a two-flop synchronizer.

Software uses a ping-pong scheme. It writes the settings of the idle path and flips the path-select bit in the same write. The hardware then hands the output over and raises a busy flag. Busy stays high until the synchronized enables show that the new source alone is driving the output. While busy is high, the hardware ignores writes that could disturb the clocks in the hand-over. Software waits for busy to clear before it issues the next change.

Top module: `cpu_clk_selector`

## Requirements
- R1: After reset the control word reads as all zeros (busy low, path 0 active, dynamic path routed, enable clear, both paths on crystal with no division), and the output runs at the crystal rate.
- R2: The 2-bit source field of a path selects the crystal for code 0, the half-rate clock for code 1 and the third-rate clock for code 2. Code 3 also selects the crystal.
- R3: The 6-bit divider field holds the division ratio minus one. Bypass bit 1 routes the divided clock and bypass bit 0 routes the undivided source whatever the divider field holds. Field 0 divides by one.
- R4: Path 0 source, bypass and divider sit in bits [1:0], [2] and [9:4]. Path 1 uses bits [17:16], [18] and [25:20]. Bit 10 is the path select, bit 11 is the final select (1 = PLL), bit 26 is a stored enable and bit 28 is the read-only busy flag. All other bits read zero.
- R5: A write that changes bit 10 moves the output to the other path, and busy reads high from the cycle after that write until the hand-over has completed.
- R6: Bit 11 set routes the PLL clock to the output; bit 11 clear routes the selected dynamic path.
- R7: While busy is high, writes leave bits 10 and 11 and all path fields of both paths unchanged. Bit 26 still takes the written value.
- R8: Rewriting the idle path while bits 10 and 11 keep their values leaves the output frequency unchanged and busy low.
- R9: The output never carries a pulse shorter than the half period of the fastest source in use. The two enables of a selection stage are never high together, and each enable changes only while its own clock is low.
- R10: Busy rises only in the cycle after a write that changes bit 10 or bit 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cfg | input | 1 | Control register clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| clk_xtal | input | 1 | Crystal clock |
| clk_half | input | 1 | Fixed clock at half the fixed PLL rate |
| clk_third | input | 1 | Fixed clock at a third of the fixed PLL rate |
| clk_pll | input | 1 | System PLL output |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word read-back including busy |
| clk_out | output | 1 | Selected CPU clock |

## Verification
The assertions check on every cycle the parts of the hand-over that can be seen locally. No selection stage ever has both enables high. Each enable moves only while its own clock is low. A select-bit change always raises busy, and busy never rises without one. During busy the select bits and path fields stay frozen. The bench scenarios are the only place that shows the clock arithmetic: measured edge counts for every source code, divider ratio and bypass setting, correct routing after each ping-pong swap, and the absence of runt pulses at the output across all swaps.

// File: rtl/cpu_clksel_pkg.sv
package cpu_clksel_pkg;

  localparam int CFG_W       = 32;
  localparam int PRE_W       = 2;
  localparam int DIV_W       = 6;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_PATHS   = 2;

  // Field placement inside the control word
  localparam int PATH0_LSB     = 0;
  localparam int PATH1_LSB     = 16;
  localparam int POST_OFS      = 2;
  localparam int DIV_OFS       = 4;
  localparam int PATH_SEL_BIT  = 10;
  localparam int FINAL_SEL_BIT = 11;
  localparam int ENABLE_BIT    = 26;
  localparam int BUSY_BIT      = 28;

  typedef enum logic [PRE_W-1:0] {
    SRC_XTAL  = 2'd0,
    SRC_HALF  = 2'd1,
    SRC_THIRD = 2'd2,
    SRC_SPARE = 2'd3
  } pre_src_e;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             post;
    logic [DIV_W-1:0] div;
  } path_cfg_t;

  function automatic int path_lsb(input int idx);
    return (idx == 0) ? PATH0_LSB : PATH1_LSB;
  endfunction

  function automatic path_cfg_t get_path(input logic [CFG_W-1:0] w, input int idx);
    path_cfg_t c;
    int b;
    b      = path_lsb(idx);
    c.pre  = w[b +: PRE_W];
    c.post = w[b + POST_OFS];
    c.div  = w[b + DIV_OFS +: DIV_W];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] path_mask(input int idx);
    logic [CFG_W-1:0] m;
    int b;
    m = '0;
    b = path_lsb(idx);
    m[b +: PRE_W]           = '1;
    m[b + POST_OFS]         = 1'b1;
    m[b + DIV_OFS +: DIV_W] = '1;
    return m;
  endfunction

  function automatic logic [CFG_W-1:0] bit_mask(input int pos);
    logic [CFG_W-1:0] m;
    m      = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

  // Number of source cycles the divided output stays high: ceil((f+1)/2)
  function automatic logic [DIV_W:0] high_phases(input logic [DIV_W-1:0] f);
    return ({1'b0, f} + (DIV_W+1)'(2)) >> 1;
  endfunction

  // Counter runs 0..f, then wraps
  function automatic logic [DIV_W-1:0] next_count(input logic [DIV_W-1:0] cnt,
                                                  input logic [DIV_W-1:0] f);
    return (cnt >= f) ? '0 : cnt + DIV_W'(1);
  endfunction

  // A stage has settled when only the enable of the chosen side is high
  function automatic logic handover_done(input logic [1:0] en, input logic sel);
    return sel ? (en == 2'b10) : (en == 2'b01);
  endfunction

endpackage

// File: rtl/cpu_clksel_divider.sv
module cpu_clksel_divider
  import cpu_clksel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nxt;
  logic             phase_q;
  logic [DIV_W:0]   high_len;

  assign cnt_nxt  = next_count(cnt_q, div_i);
  assign high_len = high_phases(div_i);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      phase_q <= ({1'b0, cnt_nxt} < high_len);
    end
  end

  // Ratio one passes the source straight through
  assign clk_o = (div_i == '0) ? clk_i : phase_q;

endmodule

// File: rtl/cpu_clksel_path.sv
module cpu_clksel_path
  import cpu_clksel_pkg::*;
(
  input  logic      rst_n,
  input  logic      clk_xtal,
  input  logic      clk_half,
  input  logic      clk_third,
  input  path_cfg_t cfg_i,
  output logic      clk_o
);

  logic pre_clk;
  logic div_clk;

  // Source pick; only reprogrammed while this path is gated off
  always_comb begin
    case (pre_src_e'(cfg_i.pre))
      SRC_HALF:  pre_clk = clk_half;
      SRC_THIRD: pre_clk = clk_third;
      default:   pre_clk = clk_xtal;
    endcase
  end

  cpu_clksel_divider u_div (
    .clk_i (pre_clk),
    .rst_n (rst_n),
    .div_i (cfg_i.div),
    .clk_o (div_clk)
  );

  assign clk_o = cfg_i.post ? div_clk : pre_clk;

endmodule

// File: rtl/cpu_clksel_gfmux.sv
module cpu_clksel_gfmux
  import cpu_clksel_pkg::*;
#(
  parameter int STAGES   = SYNC_STAGES,
  parameter bit INIT_SEL = 1'b0
) (
  input  logic       rst_n,
  input  logic       clk_a,
  input  logic       clk_b,
  input  logic       sel_i,
  output logic       clk_o,
  output logic [1:0] en_o
);

  logic [1:0] clk_in;
  logic [1:0] en_q;

  assign clk_in = {clk_b, clk_a};

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam bit INIT_ON = (INIT_SEL == s[0]);

    logic              want;
    logic [STAGES-1:0] sync_q;
    logic              en_r;

    // Ask for this side only once the other side's enable is down
    assign want = (sel_i == s[0]) && !en_q[1-s];

    always_ff @(posedge clk_in[s] or negedge rst_n) begin
      if (!rst_n) sync_q <= {STAGES{INIT_ON}};
      else        sync_q <= {sync_q[STAGES-2:0], want};
    end

    // Enable moves on the falling edge, while this clock is low
    always_ff @(negedge clk_in[s] or negedge rst_n) begin
      if (!rst_n) en_r <= INIT_ON;
      else        en_r <= sync_q[STAGES-1];
    end

    assign en_q[s] = en_r;

    always @(en_r) begin
      if (rst_n) begin
        AST_EN_MOVES_LOW: assert (!clk_in[s]) else $error("enable moved while clock high"); // R9
      end
    end

    always @(posedge en_r) begin
      if (rst_n) begin
        AST_HANDOVER_ORDER: assert (!en_q[1-s]) else $error("enable rose before the other fell"); // R9
      end
    end
  end

  assign clk_o = (clk_a & en_q[0]) | (clk_b & en_q[1]);
  assign en_o  = en_q;

  AST_ONE_SOURCE: assert property (@(posedge clk_a) disable iff (!rst_n) !(en_q[0] && en_q[1])); // R9

endmodule

// File: rtl/cpu_clksel_ctrl.sv
module cpu_clksel_ctrl
  import cpu_clksel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic [3:0]       en_state_i,   // {final stage en[1:0], path stage en[1:0]}
  output logic [CFG_W-1:0] rd_data,
  output path_cfg_t        path_cfg_o [NUM_PATHS],
  output logic             path_sel_o,
  output logic             final_sel_o
);

  localparam logic [CFG_W-1:0] PATH_BITS = path_mask(0) | path_mask(1);
  localparam logic [CFG_W-1:0] SEL_BITS  = bit_mask(PATH_SEL_BIT) | bit_mask(FINAL_SEL_BIT);
  localparam logic [CFG_W-1:0] WR_MASK   = PATH_BITS | SEL_BITS | bit_mask(ENABLE_BIT);
  localparam logic [CFG_W-1:0] BUSY_MASK = bit_mask(ENABLE_BIT);
  localparam logic [3:0]       EN_INIT   = 4'b0101;

  logic [CFG_W-1:0]            cfg_q;
  logic [CFG_W-1:0]            wmask;
  logic [SYNC_STAGES-1:0][3:0] en_pipe;
  logic [3:0]                  en_seen;
  logic                        path_done;
  logic                        final_done;
  logic                        busy;
  logic                        sel_change;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_pipe <= {SYNC_STAGES{EN_INIT}};
    else        en_pipe <= {en_pipe[SYNC_STAGES-2:0], en_state_i};
  end

  assign en_seen    = en_pipe[SYNC_STAGES-1];
  assign path_done  = handover_done(en_seen[1:0], cfg_q[PATH_SEL_BIT]);
  assign final_done = handover_done(en_seen[3:2], cfg_q[FINAL_SEL_BIT]);
  assign busy       = !(path_done && final_done);
  assign wmask      = busy ? BUSY_MASK : WR_MASK;
  assign sel_change = wr_en && (((wr_data ^ cfg_q) & SEL_BITS) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= (cfg_q & ~wmask) | (wr_data & wmask);
  end

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_cfg
    assign path_cfg_o[p] = get_path(cfg_q, p);
  end

  assign path_sel_o  = cfg_q[PATH_SEL_BIT];
  assign final_sel_o = cfg_q[FINAL_SEL_BIT];
  assign rd_data     = cfg_q | (CFG_W'(busy) << BUSY_BIT);

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((cfg_q & SEL_BITS) == $past(cfg_q & SEL_BITS))); // R7
  AST_PATHS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((cfg_q & PATH_BITS) == $past(cfg_q & PATH_BITS))); // R7
  AST_TOGGLE_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sel_change) |=> busy); // R5
  AST_BUSY_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sel_change) |=> !busy); // R10

endmodule

// File: rtl/cpu_clk_selector.sv
module cpu_clk_selector
  import cpu_clksel_pkg::*;
(
  input  logic        clk_cfg,
  input  logic        rst_n,
  input  logic        clk_xtal,
  input  logic        clk_half,
  input  logic        clk_third,
  input  logic        clk_pll,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        clk_out
);

  path_cfg_t              path_cfg [NUM_PATHS];
  logic [NUM_PATHS-1:0]   path_clk;
  logic                   path_sel;
  logic                   final_sel;
  logic                   dyn_clk;
  logic [1:0]             path_en;
  logic [1:0]             final_en;

  cpu_clksel_ctrl u_ctrl (
    .clk         (clk_cfg),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .en_state_i  ({final_en, path_en}),
    .rd_data     (rd_data),
    .path_cfg_o  (path_cfg),
    .path_sel_o  (path_sel),
    .final_sel_o (final_sel)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    cpu_clksel_path u_path (
      .rst_n     (rst_n),
      .clk_xtal  (clk_xtal),
      .clk_half  (clk_half),
      .clk_third (clk_third),
      .cfg_i     (path_cfg[p]),
      .clk_o     (path_clk[p])
    );
  end

  cpu_clksel_gfmux #(.INIT_SEL(1'b0)) u_path_mux (
    .rst_n (rst_n),
    .clk_a (path_clk[0]),
    .clk_b (path_clk[1]),
    .sel_i (path_sel),
    .clk_o (dyn_clk),
    .en_o  (path_en)
  );

  cpu_clksel_gfmux #(.INIT_SEL(1'b0)) u_final_mux (
    .rst_n (rst_n),
    .clk_a (dyn_clk),
    .clk_b (clk_pll),
    .sel_i (final_sel),
    .clk_o (clk_out),
    .en_o  (final_en)
  );

endmodule

// File: tb/test_cpu_clk_selector.sv
`timescale 1ns/1ps
module test_cpu_clk_selector;

  logic        clk_cfg   = 1'b0;
  logic        rst_n     = 1'b0;
  logic        clk_xtal  = 1'b0;
  logic        clk_half  = 1'b0;
  logic        clk_third = 1'b0;
  logic        clk_pll   = 1'b0;
  logic        wr_en     = 1'b0;
  logic [31:0] wr_data   = '0;
  logic [31:0] rd_data;
  logic        clk_out;

  always #10 clk_cfg   = ~clk_cfg;   // 50 MHz
  always #20 clk_xtal  = ~clk_xtal;  // 40 ns
  always #4  clk_half  = ~clk_half;  // 8 ns
  always #6  clk_third = ~clk_third; // 12 ns
  always #3  clk_pll   = ~clk_pll;   // 6 ns

  cpu_clk_selector i_cpu_clk_selector (.*);

  localparam int WINDOW = 2400;

  typedef struct packed {
    logic [1:0]  pre;
    logic        post;
    logic [5:0]  div;
    logic        fin;
    logic [15:0] period;
  } vec_t;

  localparam vec_t VECS [0:8] = '{
    '{2'd1, 1'b0, 6'd0, 1'b0, 16'd8},
    '{2'd2, 1'b0, 6'd0, 1'b0, 16'd12},
    '{2'd1, 1'b1, 6'd3, 1'b0, 16'd32},
    '{2'd2, 1'b1, 6'd1, 1'b0, 16'd24},
    '{2'd0, 1'b1, 6'd4, 1'b0, 16'd200},
    '{2'd3, 1'b0, 6'd0, 1'b0, 16'd40},
    '{2'd0, 1'b0, 6'd0, 1'b1, 16'd6},
    '{2'd1, 1'b0, 6'd5, 1'b0, 16'd8},
    '{2'd2, 1'b1, 6'd0, 1'b0, 16'd12}
  };

  int      n_checks = 0;
  int      n_err    = 0;
  int      edge_cnt = 0;
  realtime last_t   = 0.0;
  realtime min_w    = 1.0e9;
  logic [31:0] model = '0;

  always @(posedge clk_out) if (rst_n) edge_cnt++;

  always @(clk_out) begin
    if (rst_n) begin
      if (last_t > 0.0 && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
      last_t = $realtime;
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Field layout per R4: path 0 at bit 0, path 1 at bit 16; pre +0, post +2, div +4
  function automatic logic [31:0] put_path(input logic [31:0] w, input int idx,
                                           input logic [1:0] pre, input logic post,
                                           input logic [5:0] div);
    int b;
    b = (idx == 0) ? 0 : 16;
    w[b +: 2]     = pre;
    w[b + 2]      = post;
    w[b + 4 +: 6] = div;
    return w;
  endfunction

  task automatic write_cfg(input logic [31:0] d);
    @(negedge clk_cfg);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk_cfg);
    wr_en   = 1'b0;
  endtask

  task automatic wait_idle(output bit cleared);
    cleared = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (rd_data[28] == 1'b0) begin
        cleared = 1'b1;
        break;
      end
      @(negedge clk_cfg);
    end
  endtask

  task automatic measure(output int cnt);
    int c0;
    #100;
    c0 = edge_cnt;
    #(WINDOW);
    cnt = edge_cnt - c0;
  endtask

  function automatic bit near(input int a, input int e);
    return (a >= e - 1) && (a <= e + 1);
  endfunction

  initial begin : watchdog
    #1_000_000;
    n_err++;
    n_checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin : main
    int  cnt;
    bit  ok;
    int  idle;
    int  per;
    logic [31:0] w;

    #101 rst_n = 1'b1;
    @(negedge clk_cfg);

    // R1: reset state
    chk(rd_data == 32'h0, "R1 reset read-back", rd_data, 0);
    measure(cnt);
    chk(near(cnt, WINDOW / 40), "R1 crystal after reset edges", cnt, WINDOW / 40);

    // Ping-pong table
    for (int i = 0; i < 9; i++) begin
      idle = model[10] ? 0 : 1;
      w = put_path(model, idle, VECS[i].pre, VECS[i].post, VECS[i].div);
      w[10] = ~model[10];
      w[11] = VECS[i].fin;
      model = w;
      write_cfg(w);
      chk(rd_data[28] == 1'b1, $sformatf("R5 busy after toggle vec %0d", i), rd_data[28], 1);
      wait_idle(ok);
      chk(ok, $sformatf("R5 busy clears vec %0d", i), ok, 1);
      chk(rd_data == model, $sformatf("R4 read-back vec %0d", i), rd_data, model);
      measure(cnt);
      per = int'(VECS[i].period);
      chk(near(cnt, WINDOW / per),
          $sformatf("R2 R3 R5 R6 output edges vec %0d", i), cnt, WINDOW / per);
    end
    // Active path is now 1 at 12 ns

    // R8 and R10: rewrite the idle path only
    w = put_path(model, 0, 2'd1, 1'b0, 6'd0);
    model = w;
    write_cfg(w);
    chk(rd_data[28] == 1'b0, "R8 R10 busy stays low on idle rewrite", rd_data[28], 0);
    measure(cnt);
    chk(near(cnt, WINDOW / 12), "R8 output unchanged by idle rewrite", cnt, WINDOW / 12);
    chk(rd_data == model, "R8 idle rewrite read-back", rd_data, model);

    // R7: writes during busy
    w = model;
    w[10] = 1'b0;
    model = w;
    write_cfg(w);
    chk(rd_data[28] == 1'b1, "R7 busy before blocked write", rd_data[28], 1);
    write_cfg(32'hFFFF_FFFF);
    model[26] = 1'b1;
    wait_idle(ok);
    chk(ok, "R7 busy clears", ok, 1);
    chk(rd_data == model, "R7 only enable taken during busy", rd_data, model);
    measure(cnt);
    chk(near(cnt, WINDOW / 8), "R7 output follows new path", cnt, WINDOW / 8);

    // R9: no runt pulse across every swap (fastest half period is 3 ns)
    chk(min_w >= 2.5, "R9 minimum pulse width ps", longint'(min_w * 1000.0), 2500);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule